// File: doc/BRIEF.md
# Programmable Watchdog Timer with Activity Reload

This block is a byte-programmed watchdog for a peripheral controller. Software sets a count unit (one second or one minute) and a timeout of up to 255 units. A down-counter then runs from that value. When the counter runs out, or when software or an external keyboard line forces the event, the block raises a sticky fired flag. It also drives an active-low watchdog output pulse and can add an active-low keyboard-reset pulse and a tagged interrupt request. Mouse and keyboard interrupt pulses can be enabled to restart the count, so normal user activity keeps the timer from expiring.

The block has three registers behind a 2-bit address. The control register is at address 0, the timeout register at address 1 and the control/status register at address 2. A parameter gives the number of clock cycles in one second. Writes happen on a single-cycle write strobe. Reads come straight from a combinational read port.

Top module: `sio_wdt`

## Requirements
- R1: After reset all three registers read 0, the counter is stopped, `wdt_out_n` and `kbrst_n` are high, `irq_req` is low and `irq_code` is 0.
- R2: A non-zero write to the timeout register (address 1) loads the counter with that value and starts it. Reading address 1 returns the counts remaining. Writing 0 stops the counter at 0, and no expiry follows.
- R3: With control bit 3 clear, the counter drops by one every CLKS_PER_SEC cycles after the load edge. A load of N expires on the N*CLKS_PER_SEC-th clock edge after the write.
- R4: With control bit 3 set, each decrement takes 60*CLKS_PER_SEC cycles, so a load of 1 expires 60*CLKS_PER_SEC edges after the write.
- R5: On an expiry the counter stays at 0 and stopped, and status bit 4 (fired) reads 1. `wdt_out_n` goes low from the expiry edge for exactly PULSE_CYCLES cycles.
- R6: The fired bit is sticky. Writing 0 to status bit 4 clears it, and writing 1 leaves it unchanged. While it is set, an expiry makes no output pulse and no interrupt request.
- R7: Writing 1 to status bit 5 makes that bit read 1 for one cycle. On the next edge it forces an expiry and the bit reads 0 again.
- R8: With status bit 7 (mouse) or bit 6 (keyboard) set, each one-cycle pulse on the matching interrupt input reloads the counter with the last value written to the timeout register, and the one-second phase restarts. A pulse has no effect when its enable is clear or when the counter is stopped.
- R9: With control bit 2 set, a high `kbd_p20` forces an expiry on the next edge. With that bit clear, `kbd_p20` is ignored.
- R10: With control bit 1 set, an expiry also drives `kbrst_n` low for PULSE_CYCLES cycles, aligned with `wdt_out_n`. With the bit clear, `kbrst_n` stays high.
- R11: When status bits 3:0 are non-zero, an expiry raises `irq_req` for one cycle from the expiry edge, with `irq_code` equal to those bits (2 selects the system-management interrupt). At all other times `irq_req` is low and `irq_code` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 2 | Register select: 0 control, 1 timeout, 2 control/status |
| reg_wr | input | 1 | Single-cycle write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register |
| mouse_irq | input | 1 | Mouse interrupt activity pulse |
| kbd_irq | input | 1 | Keyboard interrupt activity pulse |
| kbd_p20 | input | 1 | Keyboard controller line that can force an expiry |
| wdt_out_n | output | 1 | Active-low watchdog output pulse |
| kbrst_n | output | 1 | Active-low keyboard-reset pulse |
| irq_req | output | 1 | One-cycle interrupt request on expiry |
| irq_code | output | 4 | Interrupt source code shown with the request |

## Verification
The assertions assume that every input is synchronous to `clk` and that the activity inputs are single-cycle pulses. They also assume that a register write lasts exactly one cycle, with address and data stable at the sampling edge. The bench drives every input on the falling clock edge and holds each activity pulse and write strobe for one full cycle. It raises `kbd_p20` only while the test needs it. It clears the fired flag and lets the output pulses finish before it starts the next scenario.

// File: rtl/sio_wdt_pkg.sv
package sio_wdt_pkg;

   typedef enum logic [1:0] {
      ADDR_CTRL = 2'd0,
      ADDR_TMO  = 2'd1,
      ADDR_CSR  = 2'd2,
      ADDR_NONE = 2'd3
   } wdt_addr_e;

   // control register bit positions
   localparam int CTRL_UNIT60_BIT = 3;
   localparam int CTRL_P20_BIT    = 2;
   localparam int CTRL_KBRST_BIT  = 1;

   // control/status register bit positions
   localparam int CSR_MOUSE_BIT = 7;
   localparam int CSR_KBD_BIT   = 6;
   localparam int CSR_FORCE_BIT = 5;
   localparam int CSR_FIRED_BIT = 4;
   localparam int CSR_SEL_W     = 4;

endpackage

// File: rtl/sio_wdt_regs.sv
module sio_wdt_regs
   import sio_wdt_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        reg_addr,
   input  logic              reg_wr,
   input  logic [DATA_W-1:0] reg_wdata,
   input  logic              fire_set,
   output logic [DATA_W-1:0] ctrl_q,
   output logic              mouse_en,
   output logic              kbd_en,
   output logic              force_q,
   output logic              fired_q,
   output logic [CSR_SEL_W-1:0] irq_sel,
   output logic              tmo_wr,
   output logic [DATA_W-1:0] reload_val
);

   logic ctrl_wr;
   logic csr_wr;

   assign ctrl_wr = reg_wr && (reg_addr == ADDR_CTRL);
   assign tmo_wr  = reg_wr && (reg_addr == ADDR_TMO);
   assign csr_wr  = reg_wr && (reg_addr == ADDR_CSR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (ctrl_wr) begin
         ctrl_q <= reg_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reload_val <= '0;
      end else if (tmo_wr) begin
         reload_val <= reg_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mouse_en <= 1'b0;
         kbd_en   <= 1'b0;
         irq_sel  <= '0;
      end else if (csr_wr) begin
         mouse_en <= reg_wdata[CSR_MOUSE_BIT];
         kbd_en   <= reg_wdata[CSR_KBD_BIT];
         irq_sel  <= reg_wdata[CSR_SEL_W-1:0];
      end
   end

   // force strobe lives for one cycle only
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         force_q <= 1'b0;
      end else begin
         force_q <= csr_wr && reg_wdata[CSR_FORCE_BIT];
      end
   end

   // sticky fired flag: hardware set wins over a software clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fired_q <= 1'b0;
      end else if (fire_set) begin
         fired_q <= 1'b1;
      end else if (csr_wr && !reg_wdata[CSR_FIRED_BIT]) begin
         fired_q <= 1'b0;
      end
   end

endmodule

// File: rtl/sio_wdt_prescaler.sv
module sio_wdt_prescaler #(
   parameter int CLKS_PER_SEC = 1000,
   parameter int SECS_PER_MIN = 60
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic clear,
   input  logic unit60,
   output logic dec_tick
);

   localparam int MIN_W = (SECS_PER_MIN > 1) ? $clog2(SECS_PER_MIN) : 1;

   logic sec_tick;
   logic [MIN_W-1:0] min_cnt;

   generate
      if (CLKS_PER_SEC == 1) begin : g_sec_direct
         assign sec_tick = run && !clear;
      end else begin : g_sec_count
         localparam int SEC_W = $clog2(CLKS_PER_SEC);
         logic [SEC_W-1:0] sec_cnt;
         logic             sec_wrap;

         assign sec_wrap = (sec_cnt == SEC_W'(CLKS_PER_SEC - 1));
         assign sec_tick = run && !clear && sec_wrap;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sec_cnt <= '0;
            end else if (clear || !run || sec_wrap) begin
               sec_cnt <= '0;
            end else begin
               sec_cnt <= sec_cnt + 1'b1;
            end
         end
      end
   endgenerate

   logic min_wrap;
   assign min_wrap = (min_cnt == MIN_W'(SECS_PER_MIN - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         min_cnt <= '0;
      end else if (clear || !run) begin
         min_cnt <= '0;
      end else if (sec_tick) begin
         min_cnt <= min_wrap ? '0 : min_cnt + 1'b1;
      end
   end

   assign dec_tick = unit60 ? (sec_tick && min_wrap) : sec_tick;

endmodule

// File: rtl/sio_wdt_counter.sv
module sio_wdt_counter #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             trig,
   input  logic             activity,
   input  logic [CNT_W-1:0] reload_val,
   input  logic             dec_tick,
   output logic [CNT_W-1:0] cnt_q,
   output logic             running_q,
   output logic             reload_hit,
   output logic             expire_evt
);

   logic natural_end;

   assign reload_hit  = running_q && activity && !load && !trig;
   assign natural_end = running_q && dec_tick && (cnt_q == CNT_W'(1))
                        && !load && !reload_hit;
   assign expire_evt  = (trig && !load) || natural_end;

   // priority: software load, forced trigger, activity reload, decrement
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q     <= '0;
         running_q <= 1'b0;
      end else if (load) begin
         cnt_q     <= load_val;
         running_q <= (load_val != '0);
      end else if (trig) begin
         cnt_q     <= '0;
         running_q <= 1'b0;
      end else if (reload_hit) begin
         cnt_q     <= reload_val;
      end else if (running_q && dec_tick) begin
         cnt_q     <= cnt_q - 1'b1;
         running_q <= (cnt_q != CNT_W'(1));
      end
   end

endmodule

// File: rtl/sio_wdt_pulse.sv
module sio_wdt_pulse #(
   parameter int LEN = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic out_n
);

   localparam int LW = $clog2(LEN + 1);

   logic [LW-1:0] left_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         left_q <= '0;
      end else if (start) begin
         left_q <= LW'(LEN);
      end else if (left_q != '0) begin
         left_q <= left_q - 1'b1;
      end
   end

   assign out_n = (left_q == '0);

endmodule

// File: rtl/sio_wdt.sv
module sio_wdt
   import sio_wdt_pkg::*;
#(
   parameter int DATA_W       = 8,
   parameter int CLKS_PER_SEC = 1000,
   parameter int SECS_PER_MIN = 60,
   parameter int PULSE_CYCLES = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        reg_addr,
   input  logic              reg_wr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              mouse_irq,
   input  logic              kbd_irq,
   input  logic              kbd_p20,
   output logic              wdt_out_n,
   output logic              kbrst_n,
   output logic              irq_req,
   output logic [CSR_SEL_W-1:0] irq_code
);

   generate
      if (DATA_W != 8) begin : g_bad_width
         $error("sio_wdt: register bit layout needs DATA_W of 8");
      end
      if (CLKS_PER_SEC < 1) begin : g_bad_clks
         $error("sio_wdt: CLKS_PER_SEC must be at least 1");
      end
      if (SECS_PER_MIN < 2) begin : g_bad_min
         $error("sio_wdt: SECS_PER_MIN must be at least 2");
      end
      if (PULSE_CYCLES < 1) begin : g_bad_pulse
         $error("sio_wdt: PULSE_CYCLES must be at least 1");
      end
   endgenerate

   logic [DATA_W-1:0]    ctrl_q;
   logic                 mouse_en;
   logic                 kbd_en;
   logic                 force_q;
   logic                 fired_q;
   logic [CSR_SEL_W-1:0] irq_sel;
   logic                 tmo_wr;
   logic [DATA_W-1:0]    reload_val;
   logic [DATA_W-1:0]    cnt_q;
   logic                 running_q;
   logic                 reload_hit;
   logic                 expire_evt;
   logic                 dec_tick;
   logic                 fire_sig;
   logic                 trig;
   logic                 activity;
   logic                 presc_clear;

   sio_wdt_regs #(.DATA_W(DATA_W)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .reg_addr   (reg_addr),
      .reg_wr     (reg_wr),
      .reg_wdata  (reg_wdata),
      .fire_set   (fire_sig),
      .ctrl_q     (ctrl_q),
      .mouse_en   (mouse_en),
      .kbd_en     (kbd_en),
      .force_q    (force_q),
      .fired_q    (fired_q),
      .irq_sel    (irq_sel),
      .tmo_wr     (tmo_wr),
      .reload_val (reload_val)
   );

   assign trig     = force_q || (ctrl_q[CTRL_P20_BIT] && kbd_p20);
   assign activity = (mouse_en && mouse_irq) || (kbd_en && kbd_irq);

   sio_wdt_counter #(.CNT_W(DATA_W)) u_counter (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (tmo_wr),
      .load_val   (reg_wdata),
      .trig       (trig),
      .activity   (activity),
      .reload_val (reload_val),
      .dec_tick   (dec_tick),
      .cnt_q      (cnt_q),
      .running_q  (running_q),
      .reload_hit (reload_hit),
      .expire_evt (expire_evt)
   );

   assign presc_clear = tmo_wr || reload_hit || trig;

   sio_wdt_prescaler #(
      .CLKS_PER_SEC (CLKS_PER_SEC),
      .SECS_PER_MIN (SECS_PER_MIN)
   ) u_presc (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (running_q),
      .clear    (presc_clear),
      .unit60   (ctrl_q[CTRL_UNIT60_BIT]),
      .dec_tick (dec_tick)
   );

   // an expiry is only signalled while the fired flag is clear
   assign fire_sig = expire_evt && !fired_q;

   sio_wdt_pulse #(.LEN(PULSE_CYCLES)) u_wdt_pulse (
      .clk   (clk),
      .rst_n (rst_n),
      .start (fire_sig),
      .out_n (wdt_out_n)
   );

   sio_wdt_pulse #(.LEN(PULSE_CYCLES)) u_kbrst_pulse (
      .clk   (clk),
      .rst_n (rst_n),
      .start (fire_sig && ctrl_q[CTRL_KBRST_BIT]),
      .out_n (kbrst_n)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_req  <= 1'b0;
         irq_code <= '0;
      end else if (fire_sig && (irq_sel != '0)) begin
         irq_req  <= 1'b1;
         irq_code <= irq_sel;
      end else begin
         irq_req  <= 1'b0;
         irq_code <= '0;
      end
   end

   always_comb begin
      case (reg_addr)
         ADDR_CTRL: reg_rdata = ctrl_q;
         ADDR_TMO:  reg_rdata = cnt_q;
         ADDR_CSR:  reg_rdata = {mouse_en, kbd_en, force_q, fired_q, irq_sel};
         default:   reg_rdata = '0;
      endcase
   end

endmodule

// File: rtl/sio_wdt_chk.sv
module sio_wdt_chk #(
   parameter int CNT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tmo_wr,
   input logic             csr_wr,
   input logic             wdata_fired,
   input logic             wdata_force,
   input logic             fired_q,
   input logic             force_q,
   input logic [CNT_W-1:0] cnt_q,
   input logic             running_q,
   input logic             reload_hit,
   input logic             wdt_out_n,
   input logic             irq_req,
   input logic [3:0]       irq_code
);

   assert_stopped_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!running_q && !tmo_wr) |=> $stable(cnt_q));

   assert_no_count_up_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (running_q && !tmo_wr && !reload_hit) |=> (cnt_q <= $past(cnt_q)));

   assert_pulse_on_new_fire_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wdt_out_n) |-> $rose(fired_q));

   assert_fired_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (fired_q && !(csr_wr && !wdata_fired)) |=> fired_q);

   assert_force_self_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (force_q && !(csr_wr && wdata_force)) |=> !force_q);

   assert_irq_code_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> (irq_code != 4'd0));

endmodule

bind sio_wdt sio_wdt_chk #(.CNT_W(DATA_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .tmo_wr      (tmo_wr),
   .csr_wr      (reg_wr && (reg_addr == 2'd2)),
   .wdata_fired (reg_wdata[4]),
   .wdata_force (reg_wdata[5]),
   .fired_q     (fired_q),
   .force_q     (force_q),
   .cnt_q       (cnt_q),
   .running_q   (running_q),
   .reload_hit  (reload_hit),
   .wdt_out_n   (wdt_out_n),
   .irq_req     (irq_req),
   .irq_code    (irq_code)
);

// File: tb/sio_wdt_bench.sv
module sio_wdt_bench;

   localparam int CPS   = 8;
   localparam int PULSE = 3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] reg_addr = 2'd0;
   logic       reg_wr = 1'b0;
   logic [7:0] reg_wdata = 8'd0;
   logic [7:0] reg_rdata;
   logic       mouse_irq = 1'b0;
   logic       kbd_irq = 1'b0;
   logic       kbd_p20 = 1'b0;
   logic       wdt_out_n;
   logic       kbrst_n;
   logic       irq_req;
   logic [3:0] irq_code;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #10 clk = ~clk;

   sio_wdt #(
      .CLKS_PER_SEC (CPS),
      .PULSE_CYCLES (PULSE)
   ) u_sio_wdt (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_addr  (reg_addr),
      .reg_wr    (reg_wr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .mouse_irq (mouse_irq),
      .kbd_irq   (kbd_irq),
      .kbd_p20   (kbd_p20),
      .wdt_out_n (wdt_out_n),
      .kbrst_n   (kbrst_n),
      .irq_req   (irq_req),
      .irq_code  (irq_code)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      reg_addr  = a;
      reg_wdata = d;
      reg_wr    = 1'b1;
      @(negedge clk);
      reg_wr    = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic settle();
      tick(PULSE + 1);
      wr(2'd0, 8'h00);
      wr(2'd2, 8'h00);
      wr(2'd1, 8'h00);
   endtask

   task automatic t_reset();
      logic [7:0] d;
      rd(2'd0, d); chk("R1 ctrl", d, 0);
      rd(2'd1, d); chk("R1 timeout", d, 0);
      rd(2'd2, d); chk("R1 csr", d, 0);
      chk("R1 wdt_out_n", wdt_out_n, 1);
      chk("R1 kbrst_n", kbrst_n, 1);
      chk("R1 irq_req", irq_req, 0);
      chk("R1 irq_code", irq_code, 0);
   endtask

   task automatic t_one_sec();
      logic [7:0] d;
      wr(2'd1, 8'd3);
      rd(2'd1, d); chk("R2 loaded readback", d, 3);
      tick(CPS - 1);
      rd(2'd1, d); chk("R3 before first step", d, 3);
      tick(1);
      rd(2'd1, d); chk("R3 first step", d, 2);
      tick(2 * CPS - 1);
      rd(2'd1, d); chk("R3 one left", d, 1);
      chk("R5 no pulse before expiry", wdt_out_n, 1);
      tick(1);
      rd(2'd1, d); chk("R5 counter at 0", d, 0);
      chk("R5 wdt pulse low", wdt_out_n, 0);
      chk("R10 kbrst stays high", kbrst_n, 1);
      chk("R11 no irq when sel 0", irq_req, 0);
      rd(2'd2, d); chk("R5 fired set", d, 8'h10);
      tick(PULSE - 1);
      chk("R5 pulse still low", wdt_out_n, 0);
      tick(1);
      chk("R5 pulse length", wdt_out_n, 1);
      tick(2 * CPS);
      rd(2'd1, d); chk("R5 stays stopped", d, 0);
      settle();
   endtask

   task automatic t_stop();
      logic [7:0] d;
      wr(2'd1, 8'd5);
      tick(3);
      wr(2'd1, 8'd0);
      rd(2'd1, d); chk("R2 write 0 stops", d, 0);
      tick(6 * CPS);
      rd(2'd1, d); chk("R2 remains 0", d, 0);
      chk("R2 no expiry pulse", wdt_out_n, 1);
      rd(2'd2, d); chk("R2 no fired", d, 0);
   endtask

   task automatic t_sixty();
      logic [7:0] d;
      wr(2'd0, 8'h08);
      wr(2'd1, 8'd1);
      tick(60 * CPS - 1);
      rd(2'd1, d); chk("R4 one left", d, 1);
      tick(1);
      rd(2'd1, d); chk("R4 expired", d, 0);
      chk("R4 pulse", wdt_out_n, 0);
      tick(PULSE + 1);
      wr(2'd0, 8'h00);
   endtask

   // runs with the fired flag still set by t_sixty
   task automatic t_sticky();
      logic [7:0] d;
      wr(2'd2, 8'h12);
      wr(2'd1, 8'd2);
      tick(2 * CPS);
      rd(2'd1, d); chk("R6 counter ran out", d, 0);
      chk("R6 no pulse while fired", wdt_out_n, 1);
      chk("R6 no irq while fired", irq_req, 0);
      rd(2'd2, d); chk("R6 fired kept", d, 8'h12);
      wr(2'd2, 8'h00);
      rd(2'd2, d); chk("R6 cleared by 0", d, 8'h00);
      wr(2'd2, 8'h10);
      rd(2'd2, d); chk("R6 write 1 does not set", d, 8'h00);
      wr(2'd2, 8'h00);
   endtask

   task automatic t_force();
      logic [7:0] d;
      wr(2'd0, 8'h02);
      wr(2'd2, 8'h22);
      rd(2'd2, d); chk("R7 force bit visible", d, 8'h22);
      chk("R7 not yet fired", wdt_out_n, 1);
      tick(1);
      chk("R7 forced pulse", wdt_out_n, 0);
      chk("R10 kbrst pulse", kbrst_n, 0);
      chk("R11 irq_req", irq_req, 1);
      chk("R11 irq_code", irq_code, 2);
      rd(2'd2, d); chk("R7 force self cleared", d, 8'h12);
      tick(1);
      chk("R11 irq one cycle", irq_req, 0);
      chk("R11 code back to 0", irq_code, 0);
      tick(PULSE - 2);
      chk("R10 kbrst still low", kbrst_n, 0);
      tick(1);
      chk("R10 kbrst released", kbrst_n, 1);
      chk("R5 wdt released", wdt_out_n, 1);
      settle();
   endtask

   task automatic t_reload();
      logic [7:0] d;
      wr(2'd2, 8'h80);
      wr(2'd1, 8'd5);
      tick(CPS + 1);
      rd(2'd1, d); chk("R8 counted down", d, 4);
      mouse_irq = 1'b1; tick(1); mouse_irq = 1'b0;
      rd(2'd1, d); chk("R8 mouse reload", d, 5);
      kbd_irq = 1'b1; tick(1); kbd_irq = 1'b0;
      rd(2'd1, d); chk("R8 kbd disabled ignored", d, 5);
      wr(2'd2, 8'hC0);
      tick(CPS - 3);
      rd(2'd1, d); chk("R8 phase restarted", d, 5);
      tick(1);
      rd(2'd1, d); chk("R8 step after reload", d, 4);
      kbd_irq = 1'b1; tick(1); kbd_irq = 1'b0;
      rd(2'd1, d); chk("R8 kbd reload", d, 5);
      wr(2'd1, 8'd0);
      mouse_irq = 1'b1; tick(1); mouse_irq = 1'b0;
      rd(2'd1, d); chk("R8 no reload when stopped", d, 0);
      tick(2 * CPS);
      chk("R8 no expiry when stopped", wdt_out_n, 1);
      wr(2'd2, 8'h00);
   endtask

   task automatic t_p20();
      logic [7:0] d;
      kbd_p20 = 1'b1;
      tick(3);
      kbd_p20 = 1'b0;
      rd(2'd2, d); chk("R9 ignored when disabled", d, 8'h00);
      chk("R9 no pulse when disabled", wdt_out_n, 1);
      wr(2'd0, 8'h04);
      kbd_p20 = 1'b1;
      tick(1);
      kbd_p20 = 1'b0;
      chk("R9 p20 forces expiry", wdt_out_n, 0);
      rd(2'd2, d); chk("R9 fired", d, 8'h10);
      settle();
   endtask

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(1);
      t_reset();
      t_one_sec();
      t_stop();
      t_sixty();
      t_sticky();
      t_force();
      t_reload();
      t_p20();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

endmodule